// File: doc/BRIEF.md
# Graphics Coprocessor Host Register Window

This block is the byte-wide register window through which a host CPU controls a graphics coprocessor. It decodes host reads and writes at a window offset, keeps the control and status bytes, and produces the control signals the rest of the coprocessor needs. These are a one-cycle start request, a one-cycle cache-flush request, an execution-permitted level, the selected memory banks and an interrupt line back to the host. Host writes that land above the register area are passed on, unchanged, as cache-data writes.

Several host accesses have side effects. Toggling the go flag in the low status byte starts the core or flushes its instruction cache, depending on the direction of the change. Writing the high program-counter byte always launches the core. Reading the high status byte acknowledges the interrupt. The execution core reports the end of a run through a stop input, which drops the go flag and raises the interrupt flag.

Top module: `gfx_host_regs`

## Requirements
- R1: After reset every register byte reads 0x00, and irq, run_ok, start_pulse, flush_pulse and cache_wr are all 0.
- R2: A host write to offset 0x30 with go (bit 5) at 0 and wdata bit 5 at 1 stores the byte and drives start_pulse high for exactly the following cycle.
- R3: A host write to offset 0x30 with go at 1 and wdata bit 5 at 0 stores the byte and drives flush_pulse high for exactly the following cycle, with no start_pulse.
- R4: A host write to offset 0x30 that leaves bit 5 unchanged only stores the byte; neither pulse occurs.
- R5: A host write to offset 0x1F stores the byte, sets go (offset 0x30 bit 5) and produces a start_pulse in the following cycle, even when go was already 1.
- R6: A host read of offset 0x31 returns the stored byte in the same cycle; afterwards bit 7 of that byte is 0 and irq is low.
- R7: Writes to offsets 0x34 and 0x36 store only bits 6:0 (bit 7 reads 0); prog_bank and rom_bank show bits 6:0 of those bytes.
- R8: Offset 0x3B always reads 0x00 and host writes to it change nothing.
- R9: run_ok is 1 exactly when go is 1 and offset 0x3A bits 3 and 4 are both 1.
- R10: irq is 1 exactly when offset 0x31 bit 7 is 1 and go is 0.
- R11: A host write at offsets 0x100 to 0x2FF produces, in the following cycle, one cache_wr cycle with cache_addr = offset − 0x100 and the written byte; it leaves the register bytes unchanged. Reads at 0x100 and above return 0x00, and writes at 0x300 and above do nothing.
- R12: ram_bank equals bits 1:0 of offset 0x3C.
- R13: core_stop clears go and sets offset 0x31 bit 7. A host write in the same cycle to the byte holding a bit takes priority for that bit: a write to 0x30 or to 0x1F decides go, and a write to 0x31 decides the flag. A core_stop in the same cycle as a read of 0x31 leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe, one access per cycle |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 10 | Window offset |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for host_addr, combinational |
| core_stop | input | 1 | Core has finished its run |
| start_pulse | output | 1 | One-cycle request to start the core |
| flush_pulse | output | 1 | One-cycle request to flush the instruction cache |
| run_ok | output | 1 | Go set and both memory-access mode bits set |
| irq | output | 1 | Interrupt request to the host |
| prog_bank | output | 7 | Program bank |
| rom_bank | output | 7 | Data ROM bank |
| ram_bank | output | 2 | Active RAM bank |
| cache_wr | output | 1 | Cache-data write strobe |
| cache_addr | output | 9 | Cache byte index |
| cache_wdata | output | 8 | Cache write data |

## Verification
The bench drives the go flag in both directions and also rewrites it with its current value. A design that compared against the wrong value would pulse start on every write, or flush when it should start. It makes core_stop coincide with writes to each status byte and to the program-counter high byte, and with a read of the high status byte. A wrong priority shows up as a lost go flag, a missed interrupt, or an acknowledge that wipes out a new stop. It also probes the bytes that are masked or read as constant, and the edges of the cache window at 0x100, 0x2FF and 0x300. Errors there appear as a stored bit 7, a version byte that reads back the written value, or cache writes that are misplaced or spill over.

// File: rtl/gfx_host_pkg.sv
package gfx_host_pkg;

   // window offsets whose behaviour other logic relies on
   localparam int OFS_PC_HI   = 'h1F;
   localparam int OFS_STAT_LO = 'h30;
   localparam int OFS_STAT_HI = 'h31;
   localparam int OFS_PBANK   = 'h34;
   localparam int OFS_RBANK   = 'h36;
   localparam int OFS_SMODE   = 'h3A;
   localparam int OFS_VER     = 'h3B;
   localparam int OFS_RAMB    = 'h3C;

   // bit positions
   localparam int GO_BIT      = 5;
   localparam int IRQ_BIT     = 7;
   localparam int SM_RAM_BIT  = 3;
   localparam int SM_ROM_BIT  = 4;

   typedef struct packed {
      logic in_regs;
      logic in_cache;
      logic pc_hi;
      logic stat_lo;
      logic stat_hi;
      logic narrow;
      logic version;
   } dec_t;

endpackage

// File: rtl/gfx_host_decode.sv
module gfx_host_decode
   import gfx_host_pkg::*;
#(
   parameter int ADDR_W     = 10,
   parameter int REG_SPAN   = 256,
   parameter int CACHE_SPAN = 512,
   parameter int RIDX_W     = 8,
   parameter int CIDX_W     = 9
) (
   input  logic [ADDR_W-1:0] addr,
   output dec_t              dec,
   output logic [RIDX_W-1:0] reg_idx,
   output logic [CIDX_W-1:0] cache_idx
);

   localparam int WIN_END = REG_SPAN + CACHE_SPAN;

   logic [ADDR_W:0] a_ext;

   always_comb begin
      a_ext       = {1'b0, addr};
      reg_idx     = addr[RIDX_W-1:0];
      cache_idx   = CIDX_W'(addr - ADDR_W'(REG_SPAN));
      dec.in_regs = a_ext < (ADDR_W+1)'(REG_SPAN);
      dec.in_cache = !dec.in_regs && (a_ext < (ADDR_W+1)'(WIN_END));
      dec.pc_hi   = dec.in_regs && (reg_idx == RIDX_W'(OFS_PC_HI));
      dec.stat_lo = dec.in_regs && (reg_idx == RIDX_W'(OFS_STAT_LO));
      dec.stat_hi = dec.in_regs && (reg_idx == RIDX_W'(OFS_STAT_HI));
      dec.narrow  = dec.in_regs && ((reg_idx == RIDX_W'(OFS_PBANK)) ||
                                    (reg_idx == RIDX_W'(OFS_RBANK)));
      dec.version = dec.in_regs && (reg_idx == RIDX_W'(OFS_VER));
   end

endmodule

// File: rtl/gfx_host_regfile.sv
module gfx_host_regfile
   import gfx_host_pkg::*;
#(
   parameter int REG_SPAN = 256,
   parameter int RIDX_W   = 8,
   parameter int DATA_W   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic              in_regs,
   input  logic [RIDX_W-1:0] idx,
   input  logic [DATA_W-1:0] wdata,
   input  logic              sel_pc_hi,
   input  logic              sel_stat_hi,
   input  logic              sel_narrow,
   input  logic              sel_version,
   input  logic              core_stop,
   output logic [DATA_W-1:0] rdata,
   output logic              go_flag,
   output logic              irq_flag,
   output logic              sm_ram,
   output logic              sm_rom,
   output logic [DATA_W-2:0] pbank,
   output logic [DATA_W-2:0] rbank,
   output logic [1:0]        ram_sel
);

   localparam logic [DATA_W-1:0] FULL_MASK   = '1;
   localparam logic [DATA_W-1:0] NARROW_MASK = {1'b0, {(DATA_W-1){1'b1}}};

   logic [DATA_W-1:0] regs [REG_SPAN];
   logic [DATA_W-1:0] wmask;

   assign wmask = sel_narrow ? NARROW_MASK : FULL_MASK;

   // later assignments win: read-ack < core stop < host write < pc-hi go force
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < REG_SPAN; i++) regs[i] <= '0;
      end else begin
         if (rd_en && sel_stat_hi) regs[OFS_STAT_HI][IRQ_BIT] <= 1'b0;
         if (core_stop) begin
            regs[OFS_STAT_LO][GO_BIT]  <= 1'b0;
            regs[OFS_STAT_HI][IRQ_BIT] <= 1'b1;
         end
         if (wr_en && !sel_version) regs[idx] <= wdata & wmask;
         if (wr_en && sel_pc_hi) regs[OFS_STAT_LO][GO_BIT] <= 1'b1;
      end
   end

   always_comb begin
      rdata    = (in_regs && !sel_version) ? regs[idx] : '0;
      go_flag  = regs[OFS_STAT_LO][GO_BIT];
      irq_flag = regs[OFS_STAT_HI][IRQ_BIT];
      sm_ram   = regs[OFS_SMODE][SM_RAM_BIT];
      sm_rom   = regs[OFS_SMODE][SM_ROM_BIT];
      pbank    = regs[OFS_PBANK][DATA_W-2:0];
      rbank    = regs[OFS_RBANK][DATA_W-2:0];
      ram_sel  = regs[OFS_RAMB][1:0];
   end

endmodule

// File: rtl/gfx_host_ctrl.sv
module gfx_host_ctrl
   import gfx_host_pkg::*;
#(
   parameter int    CIDX_W        = 9,
   parameter int    DATA_W        = 8,
   parameter bit    CACHE_FWD_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_wr,
   input  logic              sel_pc_hi,
   input  logic              sel_stat_lo,
   input  logic              sel_cache,
   input  logic [CIDX_W-1:0] cache_idx,
   input  logic [DATA_W-1:0] wdata,
   input  logic              go_flag,
   input  logic              irq_flag,
   input  logic              sm_ram,
   input  logic              sm_rom,
   output logic              start_pulse,
   output logic              flush_pulse,
   output logic              irq,
   output logic              run_ok,
   output logic              cache_wr,
   output logic [CIDX_W-1:0] cache_addr,
   output logic [DATA_W-1:0] cache_wdata
);

   logic start_d, flush_d;

   always_comb begin
      start_d = host_wr && (sel_pc_hi || (sel_stat_lo && !go_flag && wdata[GO_BIT]));
      flush_d = host_wr && sel_stat_lo && go_flag && !wdata[GO_BIT];
      irq     = irq_flag && !go_flag;
      run_ok  = go_flag && sm_ram && sm_rom;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_pulse <= 1'b0;
         flush_pulse <= 1'b0;
      end else begin
         start_pulse <= start_d;
         flush_pulse <= flush_d;
      end
   end

   generate
      if (CACHE_FWD_REG) begin : g_fwd_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cache_wr    <= 1'b0;
               cache_addr  <= '0;
               cache_wdata <= '0;
            end else begin
               cache_wr <= host_wr && sel_cache;
               if (host_wr && sel_cache) begin
                  cache_addr  <= cache_idx;
                  cache_wdata <= wdata;
               end
            end
         end
      end else begin : g_fwd_comb
         always_comb begin
            cache_wr    = host_wr && sel_cache;
            cache_addr  = cache_idx;
            cache_wdata = wdata;
         end
      end
   endgenerate

endmodule

// File: rtl/gfx_host_regs.sv
module gfx_host_regs
   import gfx_host_pkg::*;
#(
   parameter int ADDR_W        = 10,
   parameter int REG_SPAN      = 256,
   parameter int CACHE_SPAN    = 512,
   parameter bit CACHE_FWD_REG = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          host_wr,
   input  logic                          host_rd,
   input  logic [ADDR_W-1:0]             host_addr,
   input  logic [7:0]                    host_wdata,
   output logic [7:0]                    host_rdata,
   input  logic                          core_stop,
   output logic                          start_pulse,
   output logic                          flush_pulse,
   output logic                          run_ok,
   output logic                          irq,
   output logic [6:0]                    prog_bank,
   output logic [6:0]                    rom_bank,
   output logic [1:0]                    ram_bank,
   output logic                          cache_wr,
   output logic [$clog2(CACHE_SPAN)-1:0] cache_addr,
   output logic [7:0]                    cache_wdata
);

   localparam int RIDX_W = $clog2(REG_SPAN);
   localparam int CIDX_W = $clog2(CACHE_SPAN);
   localparam int DATA_W = 8;

   generate
      if (REG_SPAN < 64 || (1 << RIDX_W) != REG_SPAN) begin : g_bad_regspan
         $error("REG_SPAN must be a power of two of at least 64");
      end
      if ((1 << CIDX_W) != CACHE_SPAN) begin : g_bad_cspan
         $error("CACHE_SPAN must be a power of two");
      end
      if (REG_SPAN + CACHE_SPAN > (1 << ADDR_W) || ADDR_W < CIDX_W) begin : g_bad_addr
         $error("ADDR_W too narrow for the window");
      end
   endgenerate

   dec_t              dec;
   logic [RIDX_W-1:0] reg_idx;
   logic [CIDX_W-1:0] cache_idx;
   logic              go_flag, irq_flag, sm_ram, sm_rom;

   gfx_host_decode #(
      .ADDR_W(ADDR_W), .REG_SPAN(REG_SPAN), .CACHE_SPAN(CACHE_SPAN),
      .RIDX_W(RIDX_W), .CIDX_W(CIDX_W)
   ) u_decode (
      .addr(host_addr), .dec(dec), .reg_idx(reg_idx), .cache_idx(cache_idx)
   );

   gfx_host_regfile #(
      .REG_SPAN(REG_SPAN), .RIDX_W(RIDX_W), .DATA_W(DATA_W)
   ) u_regfile (
      .clk(clk), .rst_n(rst_n),
      .wr_en(host_wr && dec.in_regs), .rd_en(host_rd), .in_regs(dec.in_regs),
      .idx(reg_idx), .wdata(host_wdata),
      .sel_pc_hi(dec.pc_hi), .sel_stat_hi(dec.stat_hi),
      .sel_narrow(dec.narrow), .sel_version(dec.version),
      .core_stop(core_stop), .rdata(host_rdata),
      .go_flag(go_flag), .irq_flag(irq_flag), .sm_ram(sm_ram), .sm_rom(sm_rom),
      .pbank(prog_bank), .rbank(rom_bank), .ram_sel(ram_bank)
   );

   gfx_host_ctrl #(
      .CIDX_W(CIDX_W), .DATA_W(DATA_W), .CACHE_FWD_REG(CACHE_FWD_REG)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr),
      .sel_pc_hi(dec.pc_hi), .sel_stat_lo(dec.stat_lo), .sel_cache(dec.in_cache),
      .cache_idx(cache_idx), .wdata(host_wdata),
      .go_flag(go_flag), .irq_flag(irq_flag), .sm_ram(sm_ram), .sm_rom(sm_rom),
      .start_pulse(start_pulse), .flush_pulse(flush_pulse),
      .irq(irq), .run_ok(run_ok),
      .cache_wr(cache_wr), .cache_addr(cache_addr), .cache_wdata(cache_wdata)
   );

endmodule

// File: rtl/gfx_host_regs_chk.sv
module gfx_host_regs_chk #(
   parameter int ADDR_W     = 10,
   parameter int REG_SPAN   = 256,
   parameter int CACHE_SPAN = 512
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          host_wr,
   input logic                          host_rd,
   input logic [ADDR_W-1:0]             host_addr,
   input logic [7:0]                    host_wdata,
   input logic [7:0]                    host_rdata,
   input logic                          core_stop,
   input logic                          start_pulse,
   input logic                          flush_pulse,
   input logic                          irq,
   input logic [6:0]                    prog_bank,
   input logic                          cache_wr,
   input logic [$clog2(CACHE_SPAN)-1:0] cache_addr
);

   localparam int CIDX_W = $clog2(CACHE_SPAN);

   logic in_cache;
   assign in_cache = (host_addr >= ADDR_W'(REG_SPAN)) &&
                     ({1'b0, host_addr} < (ADDR_W+1)'(REG_SPAN + CACHE_SPAN));

   AST_PULSES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(start_pulse && flush_pulse)); // R3

   AST_NO_WRITE_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
      !host_wr |=> !start_pulse); // R2

   AST_PC_HI_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && host_addr == ADDR_W'('h1F)) |=> start_pulse); // R5

   AST_ACK_CLEARS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && host_addr == ADDR_W'('h31) && !host_wr && !core_stop) |=> !irq); // R6

   AST_BANK_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && host_addr == ADDR_W'('h34)) |=> prog_bank == $past(host_wdata[6:0])); // R7

   AST_VERSION_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (host_addr == ADDR_W'('h3B)) |-> host_rdata == 8'h00); // R8

   AST_STOP_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      (core_stop && !host_wr) |=> irq); // R13

   AST_CACHE_FWD: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && in_cache) |=> (cache_wr &&
         cache_addr == CIDX_W'($past(host_addr) - ADDR_W'(REG_SPAN)))); // R11

   AST_CACHE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !(host_wr && in_cache) |=> !cache_wr); // R11

endmodule

bind gfx_host_regs gfx_host_regs_chk #(
   .ADDR_W(ADDR_W), .REG_SPAN(REG_SPAN), .CACHE_SPAN(CACHE_SPAN)
) u_chk (
   .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
   .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
   .core_stop(core_stop), .start_pulse(start_pulse), .flush_pulse(flush_pulse),
   .irq(irq), .prog_bank(prog_bank), .cache_wr(cache_wr), .cache_addr(cache_addr)
);

// File: tb/gfx_host_regs_tb.sv
module gfx_host_regs_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       host_wr = 1'b0, host_rd = 1'b0, core_stop = 1'b0;
   logic [9:0] host_addr = '0;
   logic [7:0] host_wdata = '0;
   logic [7:0] host_rdata;
   logic       start_pulse, flush_pulse, run_ok, irq, cache_wr;
   logic [6:0] prog_bank, rom_bank;
   logic [1:0] ram_bank;
   logic [8:0] cache_addr;
   logic [7:0] cache_wdata;

   always #10 clk = ~clk;

   gfx_host_regs u_dut (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
      .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .core_stop(core_stop), .start_pulse(start_pulse), .flush_pulse(flush_pulse),
      .run_ok(run_ok), .irq(irq), .prog_bank(prog_bank), .rom_bank(rom_bank),
      .ram_bank(ram_bank), .cache_wr(cache_wr), .cache_addr(cache_addr),
      .cache_wdata(cache_wdata)
   );

   // behavioural reference
   int    mem [256];
   int    e_start = 0, e_flush = 0, e_cwr = 0, e_caddr = 0, e_cdata = 0;
   int    checks = 0, errors = 0;
   string cur_req = "R1";

   function automatic int model_read(int a);
      if (a < 256 && a != 'h3B) return mem[a];
      return 0;
   endfunction

   task automatic check(string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h at %0t", cur_req, what, act, exp, $time);
      end
   endtask

   initial for (int i = 0; i < 256; i++) mem[i] = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 256; i++) mem[i] = 0;
         e_start = 0; e_flush = 0; e_cwr = 0; e_caddr = 0; e_cdata = 0;
      end else begin
         int a, d;
         bit go;
         a = int'(host_addr); d = int'(host_wdata);
         go = mem['h30][5];
         e_start = 0; e_flush = 0; e_cwr = 0;
         if (host_rd && a == 'h31) mem['h31] = mem['h31] & 'h7F;
         if (core_stop) begin
            mem['h30] = mem['h30] & ~'h20;
            mem['h31] = mem['h31] | 'h80;
         end
         if (host_wr) begin
            if (a < 256) begin
               if (a == 'h30 && (d[5] != go)) begin
                  if (d[5]) e_start = 1; else e_flush = 1;
               end
               if (a == 'h34 || a == 'h36) mem[a] = d & 'h7F;
               else if (a != 'h3B) mem[a] = d;
               if (a == 'h1F) begin
                  mem['h30] = mem['h30] | 'h20;
                  e_start = 1;
               end
            end else if (a < 'h300) begin
               e_cwr = 1; e_caddr = a - 'h100; e_cdata = d;
            end
         end
      end
   end

   // compare every clock, away from the active edge
   always @(negedge clk) begin
      check("start_pulse", int'(start_pulse), e_start);
      check("flush_pulse", int'(flush_pulse), e_flush);
      check("cache_wr", int'(cache_wr), e_cwr);
      if (e_cwr != 0) begin
         check("cache_addr", int'(cache_addr), e_caddr);
         check("cache_wdata", int'(cache_wdata), e_cdata);
      end
      check("irq", int'(irq), int'(mem['h31][7] && !mem['h30][5]));
      check("run_ok", int'(run_ok), int'(mem['h30][5] && mem['h3A][3] && mem['h3A][4]));
      check("prog_bank", int'(prog_bank), mem['h34] & 'h7F);
      check("rom_bank", int'(rom_bank), mem['h36] & 'h7F);
      check("ram_bank", int'(ram_bank), mem['h3C] & 3);
   end

   task automatic idle();
      @(negedge clk); #1;
      host_wr = 0; host_rd = 0; core_stop = 0;
   endtask

   task automatic wr(int a, int d, bit stop = 0);
      @(negedge clk); #1;
      host_wr = 1; host_rd = 0; host_addr = 10'(a); host_wdata = 8'(d); core_stop = stop;
      @(negedge clk); #1;
      host_wr = 0; core_stop = 0;
   endtask

   task automatic rd(int a, bit stop = 0);
      @(negedge clk); #1;
      host_wr = 0; host_rd = 1; host_addr = 10'(a); core_stop = stop;
      #5 check($sformatf("rdata[%0h]", a), int'(host_rdata), model_read(a));
      @(negedge clk); #1;
      host_rd = 0; core_stop = 0;
   endtask

   task automatic stop_only();
      @(negedge clk); #1;
      core_stop = 1;
      @(negedge clk); #1;
      core_stop = 0;
   endtask

   initial begin
      #2_000_000;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      cur_req = "R1";
      repeat (3) @(negedge clk);
      #1 rst_n = 1;
      rd('h30); rd('h31); rd('h34); rd('h3A);

      cur_req = "R2"; wr('h30, 'h20); idle(); rd('h30);
      cur_req = "R4"; wr('h30, 'h21); idle(); rd('h30);
      cur_req = "R9"; wr('h3A, 'h18); idle(); wr('h3A, 'h08); idle(); wr('h3A, 'h18);
      cur_req = "R3"; wr('h30, 'h01); idle(); rd('h30);
      cur_req = "R4"; wr('h30, 'h00); idle();
      cur_req = "R5"; wr('h1F, 'h12); idle(); rd('h1F); rd('h30);
      wr('h1F, 'h34); idle();
      cur_req = "R13"; stop_only(); idle(); rd('h30);
      cur_req = "R10"; idle();
      cur_req = "R6"; rd('h31); idle(); rd('h31);
      cur_req = "R10"; wr('h31, 'h80); idle(); wr('h30, 'h20); idle(); wr('h30, 'h00); idle();
      cur_req = "R6"; rd('h31);
      cur_req = "R13";
      wr('h30, 'h20); idle(); wr('h30, 'h20, 1); idle(); rd('h30); rd('h31);
      wr('h31, 'h00, 1); idle(); rd('h31);
      wr('h1F, 'h00); idle(); wr('h1F, 'h55, 1); idle(); rd('h30);
      rd('h31, 1); idle(); rd('h31);
      cur_req = "R7"; wr('h34, 'hFF); idle(); rd('h34); wr('h36, 'hC5); idle(); rd('h36);
      cur_req = "R8"; wr('h3B, 'h55); idle(); rd('h3B);
      cur_req = "R12"; wr('h3C, 'hFE); idle(); wr('h3C, 'h03); idle(); rd('h3C);
      cur_req = "R11";
      wr('h100, 'hA5); idle(); wr('h2FF, 'h3C); idle(); wr('h300, 'h77); idle();
      wr('h3FF, 'h11); idle(); rd('h100); rd('h2FF); rd('h000); rd('h0FF);
      cur_req = "R1";
      @(negedge clk); #1 rst_n = 0;
      @(negedge clk); @(negedge clk); #1 rst_n = 1;
      rd('h30); rd('h3C); idle();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule